// File: doc/BRIEF.md
# Port-Write Request Transmit Launcher

This block lets software stage one outgoing maintenance port-write request and send it downstream. A small register window on a 32-bit read/write bus holds a control word (destination ID, optional upper ID byte, priority, payload size and a start flag) and a 16-word payload buffer. Software fills the buffer, then writes the control word with the start flag set.

The block then offers a stream of beats on a valid/ready interface. The first beat is a descriptor that carries the destination ID, the priority and the decoded payload word count. The payload words follow from buffer index 0 upward, and the final beat is flagged. The start flag stays set for the whole transfer. While it is set, the register window is frozen against writes. The flag drops in the cycle the final payload beat is accepted, and the next request may be staged from then on.

Top module: `pwtx_launcher`

## Requirements
- R1: After reset the control word reads 0. The status word (byte offset 0x004) and any offset that is neither the control word, the status word nor a buffer slot read 0. Read data appears on the bus in the cycle after the read strobe.
- R2: The priority field sits in control bits [7:6]. Writing 2'b11 to it stores 2'b10, and any other value is stored as written.
- R3: The size field sits in control bits [5:2]. It decodes to a payload word count of 1 for size 0, of 2*n for n from 1 to 8, and of 16 for any size above 8.
- R4: The first beat of a request has the descriptor flag set. Its data is {upper ID byte [31:24], destination ID [23:16], priority [15:14], zeros [13:5], word count [4:0]}.
- R5: The payload beats follow the descriptor and carry buffer words 0 to count-1 in increasing order. The buffer word at byte offset 0x010+4*i is index i. Only the final payload beat has the last flag set. Beat data and flags hold steady while valid is high and ready is low.
- R6: Control bit [0] reads 1 from the start write until the final payload beat is accepted, and it reads 0 from the next cycle. Valid is never high while the start bit is clear.
- R7: While the start bit is set, writes to the control word and to the buffer have no effect. Writing 0 to the start bit does not stop a transfer.
- R8: The upper ID byte (control bits [31:24]) is writable when the WIDE_ID parameter is 1, and it reads 0 when WIDE_ID is 0.
- R9: Control bits [15:8] and [1] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| pw_valid | output | 1 | Downstream beat valid |
| pw_ready | input | 1 | Downstream ready |
| pw_data | output | 32 | Descriptor or payload word |
| pw_desc | output | 1 | Marks the descriptor beat |
| pw_last | output | 1 | Marks the final payload beat |

## Verification
A wrong beat index or a wrong size decode shows up on the downstream port within one accepted beat: a payload word out of order, or the last flag raised early or late against the arithmetic word count. A start flag that does not clear shows at the next control read, and one that clears early ends the stream before its last flag. A write that leaks through during a transfer shows either in the descriptor still pending on the port or in a buffer read-back right after the packet.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DESC = 2'd1,
      ST_DATA = 2'd2
   } pwtx_state_e;

   localparam int unsigned PW_CTRL_OFS = 'h000;
   localparam int unsigned PW_STAT_OFS = 'h004;

   // Priority value 3 is illegal and is folded down to 2.
   function automatic logic [1:0] pw_fix_prio(input logic [1:0] p);
      return (p == 2'b11) ? 2'b10 : p;
   endfunction

endpackage

// File: rtl/pwtx_ctrl_regs.sv
module pwtx_ctrl_regs #(
   parameter int WIDE_ID = 1,
   parameter int SZ_W    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [31:0]     wdata,
   input  logic            done,
   output logic [7:0]      dest_hi,
   output logic [7:0]      dest_lo,
   output logic [1:0]      prio,
   output logic [SZ_W-1:0] size,
   output logic            start
);
   import pwtx_pkg::*;

   logic unused_bits;
   assign unused_bits = ^{wdata[15:8], wdata[1]};

   generate
      if (WIDE_ID != 0) begin : g_wide
         logic [7:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  hi_q <= '0;
            else if (we) hi_q <= wdata[31:24];
         end
         assign dest_hi = hi_q;
      end else begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^wdata[31:24];
         assign dest_hi   = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_lo <= '0;
         prio    <= '0;
         size    <= '0;
      end else if (we) begin
         dest_lo <= wdata[23:16];
         prio    <= pw_fix_prio(wdata[7:6]);
         size    <= wdata[2 +: SZ_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              start <= 1'b0;
      else if (done)           start <= 1'b0;
      else if (we && wdata[0]) start <= 1'b1;
   end

endmodule

// File: rtl/pwtx_payload_buf.sv
module pwtx_payload_buf #(
   parameter int WORDS  = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  bus_idx,
   output logic [DATA_W-1:0] bus_q,
   input  logic [IDX_W-1:0]  strm_idx,
   output logic [DATA_W-1:0] strm_q
);
   // Plain storage, intentionally left uninitialised at reset.
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign bus_q  = mem[bus_idx];
   assign strm_q = mem[strm_idx];

endmodule

// File: rtl/pwtx_streamer.sv
module pwtx_streamer #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        dest_hi,
   input  logic [7:0]        dest_lo,
   input  logic [1:0]        prio,
   input  logic [CNT_W-1:0]  word_cnt,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_data,
   output logic              pw_valid,
   input  logic              pw_ready,
   output logic [DATA_W-1:0] pw_data,
   output logic              pw_desc,
   output logic              pw_last,
   output logic              done
);
   import pwtx_pkg::*;

   localparam int PAD_W = DATA_W - 18 - CNT_W;

   pwtx_state_e      st;
   logic [IDX_W-1:0] idx;
   logic             at_end;
   logic [DATA_W-1:0] desc_word;

   assign desc_word = {dest_hi, dest_lo, prio, {PAD_W{1'b0}}, word_cnt};
   assign at_end    = ({1'b0, idx} == (word_cnt - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         idx <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st  <= ST_DESC;
               idx <= '0;
            end
            ST_DESC: if (pw_ready) st <= ST_DATA;
            ST_DATA: if (pw_ready) begin
               if (at_end) st  <= ST_IDLE;
               else        idx <= idx + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rd_idx   = idx;
   assign pw_valid = (st != ST_IDLE);
   assign pw_desc  = (st == ST_DESC);
   assign pw_last  = (st == ST_DATA) && at_end;
   assign pw_data  = (st == ST_DESC) ? desc_word :
                     (st == ST_DATA) ? rd_data : '0;
   assign done     = pw_last && pw_ready;

endmodule

// File: rtl/pwtx_launcher.sv
module pwtx_launcher #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int SZ_W     = 4,
   parameter int SIZE_CAP = 8,
   parameter int BUF_BASE = 'h010,
   parameter int WIDE_ID  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pw_valid,
   input  logic              pw_ready,
   output logic [DATA_W-1:0] pw_data,
   output logic              pw_desc,
   output logic              pw_last
);
   import pwtx_pkg::*;

   localparam int BUF_WORDS = 2 * SIZE_CAP;
   localparam int IDX_W     = $clog2(BUF_WORDS);
   localparam int CNT_W     = IDX_W + 1;
   localparam int WA_W      = ADDR_W - 2;
   localparam logic [WA_W-1:0] CTRL_WA = WA_W'(PW_CTRL_OFS / 4);
   localparam logic [WA_W-1:0] BUF_LO  = WA_W'(BUF_BASE / 4);
   localparam logic [WA_W-1:0] BUF_HI  = WA_W'(BUF_BASE / 4 + BUF_WORDS);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("pwtx_launcher: DATA_W must be 32");
      end
      if (SIZE_CAP < 1 || SIZE_CAP > (1 << SZ_W) - 1) begin : g_bad_cap
         $error("pwtx_launcher: SIZE_CAP out of size field range");
      end
      if ((BUF_BASE % 4) != 0 || BUF_BASE <= PW_STAT_OFS) begin : g_bad_base
         $error("pwtx_launcher: BUF_BASE misaligned or overlapping");
      end
      if (BUF_BASE + 4 * BUF_WORDS > (1 << ADDR_W)) begin : g_bad_aw
         $error("pwtx_launcher: window exceeds ADDR_W");
      end
   endgenerate

   // Address decode
   logic [WA_W-1:0]  wa;
   logic             ctrl_hit, buf_hit;
   logic [IDX_W-1:0] buf_idx;
   logic             unused_lsb;

   assign wa         = bus_addr[ADDR_W-1:2];
   assign unused_lsb = ^bus_addr[1:0];
   assign ctrl_hit   = (wa == CTRL_WA);
   assign buf_hit    = (wa >= BUF_LO) && (wa < BUF_HI);
   assign buf_idx    = IDX_W'(wa - BUF_LO);

   // Control state
   logic [7:0]      dest_hi, dest_lo;
   logic [1:0]      prio_q;
   logic [SZ_W-1:0] size_q;
   logic            start_q;
   logic            done;
   logic            ctrl_we, buf_we;

   assign ctrl_we = bus_wr && ctrl_hit && !start_q;
   assign buf_we  = bus_wr && buf_hit  && !start_q;

   pwtx_ctrl_regs #(
      .WIDE_ID (WIDE_ID),
      .SZ_W    (SZ_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctrl_we),
      .wdata   (bus_wdata),
      .done    (done),
      .dest_hi (dest_hi),
      .dest_lo (dest_lo),
      .prio    (prio_q),
      .size    (size_q),
      .start   (start_q)
   );

   // Size field to payload word count
   logic [CNT_W-1:0] word_cnt;
   always_comb begin
      if (size_q == '0)
         word_cnt = CNT_W'(1);
      else if (int'(size_q) > SIZE_CAP)
         word_cnt = CNT_W'(BUF_WORDS);
      else
         word_cnt = {size_q[CNT_W-2:0], 1'b0};
   end

   // Payload storage
   logic [IDX_W-1:0]  strm_idx;
   logic [DATA_W-1:0] strm_q, bus_buf_q;

   pwtx_payload_buf #(
      .WORDS  (BUF_WORDS),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk      (clk),
      .we       (buf_we),
      .widx     (buf_idx),
      .wdata    (bus_wdata),
      .bus_idx  (buf_idx),
      .bus_q    (bus_buf_q),
      .strm_idx (strm_idx),
      .strm_q   (strm_q)
   );

   pwtx_streamer #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) u_strm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_q),
      .dest_hi  (dest_hi),
      .dest_lo  (dest_lo),
      .prio     (prio_q),
      .word_cnt (word_cnt),
      .rd_idx   (strm_idx),
      .rd_data  (strm_q),
      .pw_valid (pw_valid),
      .pw_ready (pw_ready),
      .pw_data  (pw_data),
      .pw_desc  (pw_desc),
      .pw_last  (pw_last),
      .done     (done)
   );

   // Registered read path
   logic [DATA_W-1:0] ctrl_word;
   assign ctrl_word = {dest_hi, dest_lo, 8'h00, prio_q,
                       {(4 - SZ_W){1'b0}}, size_q, 1'b0, start_q};

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd) begin
         if (ctrl_hit)     bus_rdata <= ctrl_word;
         else if (buf_hit) bus_rdata <= bus_buf_q;
         else              bus_rdata <= '0;
      end
   end

endmodule

// File: rtl/pwtx_launcher_chk.sv
module pwtx_launcher_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pw_valid,
   input logic        pw_ready,
   input logic [31:0] pw_data,
   input logic        pw_desc,
   input logic        pw_last,
   input logic        start_q,
   input logic [1:0]  prio_q
);

   AST_DESC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pw_valid) |-> pw_desc) else $error("descriptor not first"); // R4

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_valid && !pw_ready) |=> (pw_valid && $stable(pw_data) && $stable(pw_desc) && $stable(pw_last)))
      else $error("beat changed under backpressure"); // R5

   AST_LAST_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pw_last |-> (pw_valid && !pw_desc)) else $error("last flag on non-payload beat"); // R5

   AST_PRIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      prio_q != 2'b11) else $error("illegal priority stored"); // R2

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_valid && pw_ready && pw_last) |=> !start_q) else $error("start not cleared"); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !start_q |-> !pw_valid) else $error("valid without start"); // R6

endmodule

bind pwtx_launcher pwtx_launcher_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pw_valid (pw_valid),
   .pw_ready (pw_ready),
   .pw_data  (pw_data),
   .pw_desc  (pw_desc),
   .pw_last  (pw_last),
   .start_q  (start_q),
   .prio_q   (prio_q)
);

// File: tb/tb_pwtx_launcher.sv
`timescale 1ns/1ps
module tb_pwtx_launcher;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata, rdata_n;
   logic        pw_valid, pw_ready, pw_desc, pw_last;
   logic [31:0] pw_data;
   logic        n_valid, n_desc, n_last;
   logic [31:0] n_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pwtx_launcher dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_data(pw_data),
      .pw_desc(pw_desc), .pw_last(pw_last));

   pwtx_launcher #(.WIDE_ID(0)) dut_narrow (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
      .pw_valid(n_valid), .pw_ready(1'b1), .pw_data(n_data),
      .pw_desc(n_desc), .pw_last(n_last));

   function automatic logic [31:0] pat(input int i);
      return 32'h5A00_0000 ^ (32'(i) * 32'h0101_0103);
   endfunction

   function automatic int words_of(input int s);
      if (s == 0) return 1;
      if (s > 8)  return 16;
      return 2 * s;
   endfunction

   function automatic logic [1:0] fixp(input logic [1:0] p);
      return (p == 2'b11) ? 2'b10 : p;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic [31:0] dn);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; dn = rdata_n;
   endtask

   // Collects one packet: descriptor then cnt payload beats.
   task automatic run_packet(input logic [31:0] exp_desc, input int cnt, input int mode, input string tag);
      int b = 0;
      int g = 0;
      while (b <= cnt && g < 2000) begin
         @(negedge clk);
         g++;
         case (mode)
            0:       pw_ready = 1'b1;
            1:       pw_ready = (g % 2) == 1;
            default: pw_ready = (g % 3) == 0;
         endcase
         if (pw_valid && pw_ready) begin
            if (b == 0) begin
               chk("R4", {tag, " desc flag"}, {31'b0, pw_desc}, 32'd1);
               chk("R4", {tag, " desc word"}, pw_data, exp_desc);
               chk("R5", {tag, " last on desc"}, {31'b0, pw_last}, 32'd0);
            end else begin
               chk("R5", {tag, " payload word"}, pw_data, pat(b - 1));
               chk("R5", {tag, " desc flag on payload"}, {31'b0, pw_desc}, 32'd0);
               chk("R3", {tag, " last flag"}, {31'b0, pw_last}, {31'b0, b == cnt});
            end
            b++;
         end
      end
      if (g >= 2000) chk("R3", {tag, " packet completed"}, 32'(b), 32'(cnt + 1));
      @(negedge clk);
      pw_ready = 1'b0;
      chk("R6", {tag, " valid low after packet"}, {31'b0, pw_valid}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] rd, rdn, cw, dsc;
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pw_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and empty offsets
      bus_read(12'h000, rd, rdn); chk("R1", "ctrl after reset", rd, 32'h0);
      bus_read(12'h004, rd, rdn); chk("R1", "status", rd, 32'h0);
      bus_read(12'h008, rd, rdn); chk("R1", "unmapped 0x008", rd, 32'h0);
      bus_read(12'h050, rd, rdn); chk("R1", "unmapped 0x050", rd, 32'h0);
      bus_read(12'h3FC, rd, rdn); chk("R1", "unmapped 0x3FC", rd, 32'h0);
      chk("R6", "valid after reset", {31'b0, pw_valid}, 32'd0);

      // Fill buffer and read it back
      for (int i = 0; i < 16; i++) bus_write(12'(16 + 4 * i), pat(i));
      for (int i = 0; i < 16; i++) begin
         bus_read(12'(16 + 4 * i), rd, rdn);
         chk("R5", "buffer readback", rd, pat(i));
      end

      // R2 sweep of priority values, no start
      for (int p = 0; p < 4; p++) begin
         bus_write(12'h000, 32'(p) << 6);
         bus_read(12'h000, rd, rdn);
         chk("R2", "priority stored", {30'b0, rd[7:6]}, {30'b0, fixp(2'(p))});
      end

      // R8/R9: all ones except start, wide and narrow instances
      bus_write(12'h000, 32'hFFFF_FFFE);
      bus_read(12'h000, rd, rdn);
      chk("R9", "reserved bits wide", rd, 32'hFFFF_00BC);
      chk("R8", "narrow upper byte", rdn, 32'h00FF_00BC);
      bus_write(12'h000, 32'h0000_0000);

      // R3 sweep of every size value with varied backpressure
      for (int s = 0; s < 16; s++) begin
         logic [1:0] pr;
         logic [7:0] dh, dl;
         pr = 2'(s % 4);
         dh = 8'(8'hC0 + s);
         dl = 8'(s * 7 + 1);
         cw = {dh, dl, 8'hA5, pr, 4'(s), 2'b01};
         dsc = {dh, dl, fixp(pr), 9'b0, 5'(words_of(s))};
         bus_write(12'h000, cw);
         run_packet(dsc, words_of(s), s % 3, $sformatf("size%0d", s));
         bus_read(12'h000, rd, rdn);
         chk("R6", "start cleared, fields kept", rd, {dh, dl, 8'h00, fixp(pr), 4'(s), 2'b00});
      end

      // R6/R7: busy window with ready held low
      cw = {8'h12, 8'h34, 8'h00, 2'b01, 4'd1, 2'b01};
      dsc = {8'h12, 8'h34, 2'b01, 9'b0, 5'd2};
      bus_write(12'h000, cw);
      repeat (3) @(negedge clk);
      chk("R4", "desc pending", {30'b0, pw_valid, pw_desc}, 32'd3);
      bus_read(12'h000, rd, rdn);
      chk("R6", "start reads 1 in transfer", rd, cw);
      bus_write(12'h000, 32'h0000_0000);
      bus_write(12'h010, 32'hDEAD_BEEF);
      bus_read(12'h000, rd, rdn);
      chk("R7", "ctrl write ignored when busy", rd, cw);
      chk("R7", "desc unchanged by busy write", pw_data, dsc);
      run_packet(dsc, 2, 2, "busy");
      bus_read(12'h000, rd, rdn);
      chk("R6", "start clear after busy packet", rd, {cw[31:1], 1'b0});
      bus_read(12'h010, rd, rdn);
      chk("R7", "buffer write ignored when busy", rd, pat(0));

      // Buffer write accepted again once idle
      bus_write(12'h010, 32'hDEAD_BEEF);
      bus_read(12'h010, rd, rdn);
      chk("R7", "buffer writable when idle", rd, 32'hDEAD_BEEF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule